// File: doc/BRIEF.md
# Wrap-then-Saturate Fixed-Point Accumulator

This block sums a stream of signed two's complement samples in a fixed Q format. A start pulse opens a run and an operand qualifier marks each sample to add. A last flag marks the final sample of the run. The running sum is held in a register that is wider than a sample by a number of guard bits. Inside that register the sum wraps modulo 2^(N+G) and is never clamped. Only when the result is stored is it limited to the N-bit range. So partial sums that overflow and later cancel still give the exact total.

A second mode clamps every partial sum to the N-bit range before the next sample is added. The two behaviours can then be compared on the same data. The mode is sampled when a run starts and holds for the whole run. The stored result is held until the next store. It comes with a one-cycle done pulse and a sticky clip flag.

Top module: `wsacc_top`

## Requirements
- R1: While reset is asserted (synchronous, active low), and in the first cycle after it, `result_o` is 0 and `done_o` and `clip_o` are 0.
- R2: A start pulse resets the running sum to zero. An operand with `in_valid_i` high in the start cycle is added to that zero sum. If `in_last_i` is also high, the run is a single term.
- R3: In per-add mode, the overflow of an N-bit add is flagged only when both operands have the same sign bit and the sum's sign bit differs from it. Adding a positive and a negative operand never saturates. For example, 127 + (-128) + 127 gives 126 with no clip.
- R4: In wrap mode (`mode_i` = 0), overflow of the N-bit range in a partial sum causes no clamping. The sum register is N+G bits wide and wraps modulo 2^(N+G). If the true total fits N bits, the stored result equals it, however often a partial sum left the N-bit or the N+G-bit range.
- R5: The positive limit is 0 followed by all ones (0x7F for N=8, 0.9921875 in Q7). For example, 0x60 + 0x40 (0.75 + 0.5) stores 0x7F in either mode.
- R6: The negative limit is 1 followed by all zeros (0x80 for N=8, -1 in Q7). It is used for any total below the N-bit range.
- R7: In per-add mode (`mode_i` = 1), each partial sum is clamped to the N-bit range before the next operand is added. For example, 100 + 100 - 90 gives 37 (wrap mode gives 110).
- R8: The result is stored, and `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the last operand. `result_o` changes only in that cycle.
- R9: `clip_o` is cleared by start. On store, it is set if the wrapped sum lies outside the N-bit range, or if any add of a per-add run saturated. It holds until the next start.
- R10: Operands presented while no run is open are ignored. That covers operands before any start and operands after the last one. They give no done pulse and do not change `result_o`.
- R11: `mode_i` is sampled only in the start cycle. Changing it during a run does not change that run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new run and clears the sum and the clip flag |
| mode_i | input | 1 | 0: wrap and clamp at store; 1: clamp after every add (sampled at start) |
| in_valid_i | input | 1 | Operand qualifier |
| in_data_i | input | DATA_W | Signed operand |
| in_last_i | input | 1 | Marks the final operand of the run |
| result_o | output | DATA_W | Stored, clamped result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| clip_o | output | 1 | Sticky: the stored result was clipped |

## Verification
The assertions check on every cycle the properties that hold at all times:
- a mixed-sign add never raises the overflow flag, and a saturated sum is exactly the limit of the operands' sign;
- a store follows an accepted last operand by exactly one cycle, and `done_o` never lasts two cycles;
- `result_o` moves only with `done_o`;
- a start leaves the clip flag clear.

The numeric outcomes can only be shown by the bench's scenarios, which compare the stored value with a model computed from the requirements:
- partial sums that wrap past the guard bits and cancel;
- the contrast between the two modes on the same data;
- the two limits;
- ignored idle operands;
- a mode change during a run.

// File: rtl/wsacc_pkg.sv
// Package: wsacc_pkg
// Shared types for the wrap-then-saturate accumulator.
// Assumes nothing beyond standard two's complement operands.
package wsacc_pkg;

    // Accumulation mode, sampled at start of a run
    typedef enum logic {
        ACC_WRAP     = 1'b0,   // wrap inside, clamp once at store
        ACC_SAT_EACH = 1'b1    // clamp every partial sum
    } acc_mode_e;

endpackage

// File: rtl/wsacc_satadd.sv
// Module: wsacc_satadd
// Adds two signed W-bit values. It detects overflow with the sign rule:
// the operands share a sign and the raw sum has the other sign.
// With SATURATE=1 the sum is replaced by the limit of the operand sign
// when overflow occurs; with SATURATE=0 the raw wrapped sum is passed.
// Assumes both inputs are already W-bit two's complement values.
module wsacc_satadd #(
    parameter int W        = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw_sum;

    // Raw modulo-2^W sum and sign-rule overflow detection
    always_comb begin
        raw_sum = a_i + b_i;
        ovf_o   = (a_i[W-1] == b_i[W-1]) && (raw_sum[W-1] != a_i[W-1]);
    end

    generate
        if (SATURATE) begin : g_sat
            // Replace an overflowed sum by the limit of the operands' sign
            always_comb begin
                if (ovf_o) sum_o = a_i[W-1] ? NEG_LIM : POS_LIM;
                else       sum_o = raw_sum;
            end
        end else begin : g_wrap
            // Pass the wrapped sum unchanged
            always_comb sum_o = raw_sum;
        end
    endgenerate

    // R3: mixed-sign operands never overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i[W-1] != b_i[W-1]) |-> !ovf_o);

    // R5: positive overflow saturates to 0 followed by ones
    p_pos_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (SATURATE && ovf_o && !a_i[W-1]) |-> (sum_o == POS_LIM));

    // R6: negative overflow saturates to 1 followed by zeros
    p_neg_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (SATURATE && ovf_o && a_i[W-1]) |-> (sum_o == NEG_LIM));

endmodule

// File: rtl/wsacc_narrow.sv
// Module: wsacc_narrow
// Clamps a signed IN_W-bit value to the signed OUT_W-bit range and
// reports when clamping changed the value. When the widths are equal
// the value passes straight through and is never outside.
// Assumes IN_W >= OUT_W >= 2.
module wsacc_narrow #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  wide_i,
    output logic [OUT_W-1:0] narrow_o,
    output logic             outside_o
);
    localparam int EXTRA = IN_W - OUT_W;
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (EXTRA == 0) begin : g_same
            // No guard bits: nothing to clamp
            always_comb begin
                narrow_o  = wide_i;
                outside_o = 1'b0;
            end
        end else begin : g_clamp
            logic [EXTRA:0] top_bits;
            // Value fits when all bits from the narrow sign up are equal
            always_comb begin
                top_bits  = wide_i[IN_W-1:OUT_W-1];
                outside_o = !((&top_bits) || !(|top_bits));
                if (!outside_o)         narrow_o = wide_i[OUT_W-1:0];
                else if (wide_i[IN_W-1]) narrow_o = NEG_LIM;
                else                    narrow_o = POS_LIM;
            end
        end
    endgenerate

endmodule

// File: rtl/wsacc_ctrl.sv
// Module: wsacc_ctrl
// Run sequencing: opens a run on start, accepts operands while the run
// is open (including the start cycle), closes it on the last operand,
// and requests a store in the following cycle. A new start cancels a
// pending store.
// Assumes start_i is a single-cycle pulse from the user.
module wsacc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_i,
    output logic take_o,
    output logic store_o
);
    logic open_q;
    logic pend_q;

    // An operand is taken in the start cycle or while the run is open
    always_comb begin
        take_o  = valid_i && (start_i || open_q);
        store_o = pend_q && !start_i;
    end

    // Track whether a run is open and whether a store is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (take_o && last_i) open_q <= 1'b0;
            else if (start_i)     open_q <= 1'b1;
            pend_q <= take_o && last_i;
        end
    end

    // R8: a store follows an accepted last operand by one cycle
    p_store_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> $past(take_o && last_i));

    // R10: with no run open and no start, nothing is taken
    p_idle_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !start_i) |-> !take_o);

endmodule

// File: rtl/wsacc_top.sv
// Module: wsacc_top
// Signed fixed-point accumulator. In wrap mode the sum register is
// DATA_W+GUARD_W bits and wraps freely; the value is clamped to DATA_W
// bits only at store. In per-add mode every partial sum is clamped to
// DATA_W bits. Outputs a held result, a done pulse and a sticky clip.
// Assumes DATA_W >= 2 and GUARD_W >= 0.
module wsacc_top
    import wsacc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              clip_o
);
    localparam int ACC_W = DATA_W + GUARD_W;

    acc_mode_e         mode_q, mode_now;
    logic [ACC_W-1:0]  acc_q, acc_d, base_sum, wrap_sum, data_ext;
    logic [DATA_W-1:0] sat_sum, narrow_val;
    logic              sat_ovf, narrow_out, sat_seen_q;
    logic              take, store;

    wsacc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (in_valid_i),
        .last_i  (in_last_i),
        .take_o  (take),
        .store_o (store)
    );

    // Base for this cycle's add: zero on start, else the running sum
    always_comb begin
        base_sum = start_i ? '0 : acc_q;
        data_ext = {{GUARD_W{in_data_i[DATA_W-1]}}, in_data_i};
        wrap_sum = base_sum + data_ext;
        mode_now = start_i ? acc_mode_e'(mode_i) : mode_q;
    end

    wsacc_satadd #(.W(DATA_W), .SATURATE(1'b1)) u_satadd (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (base_sum[DATA_W-1:0]),
        .b_i   (in_data_i),
        .sum_o (sat_sum),
        .ovf_o (sat_ovf)
    );

    wsacc_narrow #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_narrow (
        .wide_i    (acc_q),
        .narrow_o  (narrow_val),
        .outside_o (narrow_out)
    );

    // Next running sum: per-add clamped or freely wrapped
    always_comb begin
        if (take) begin
            if (mode_now == ACC_SAT_EACH)
                acc_d = {{GUARD_W{sat_sum[DATA_W-1]}}, sat_sum};
            else
                acc_d = wrap_sum;
        end else if (start_i) begin
            acc_d = '0;
        end else begin
            acc_d = acc_q;
        end
    end

    // Running sum, latched mode and per-add saturation memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            mode_q     <= ACC_WRAP;
            sat_seen_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            if (start_i) begin
                mode_q     <= acc_mode_e'(mode_i);
                sat_seen_q <= take && (mode_now == ACC_SAT_EACH) && sat_ovf;
            end else if (take && (mode_q == ACC_SAT_EACH) && sat_ovf) begin
                sat_seen_q <= 1'b1;
            end
        end
    end

    // Store stage: clamp, done pulse and sticky clip flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
            clip_o   <= 1'b0;
        end else begin
            done_o <= store;
            if (store) begin
                result_o <= narrow_val;
                clip_o   <= narrow_out || sat_seen_q;
            end else if (start_i) begin
                clip_o <= 1'b0;
            end
        end
    end

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: result moves only together with done
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R9: a start leaves the clip flag clear
    p_clip_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !clip_o);

    // R1: outputs idle in the first cycle after reset
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0) && !done_o && !clip_o);

endmodule

// File: tb/wsacc_top_tb.sv
// Directed bench for wsacc_top (DATA_W=8, GUARD_W=2).
module wsacc_top_tb;
    localparam int N = 8;
    localparam int G = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [N-1:0] in_data_i = '0;
    logic         in_last_i = 1'b0;
    logic [N-1:0] result_o;
    logic         done_o;
    logic         clip_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    wsacc_top #(.DATA_W(N), .GUARD_W(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
        .result_o(result_o), .done_o(done_o), .clip_o(clip_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_n(input int v, output bit hit);
        hit = 1'b0;
        if (v > 127)  begin hit = 1'b1; return 127;  end
        if (v < -128) begin hit = 1'b1; return -128; end
        return v;
    endfunction

    // One run: start with first operand, toggle mode_i after start (R11)
    task automatic run_case(input string req, input bit mode, input int n, input int ops[8]);
        int  exp_val = 0;
        bit  exp_clip = 1'b0;
        bit  hit;
        int  held;
        if (mode) begin
            for (int i = 0; i < n; i++) begin
                exp_val = clamp_n(exp_val + ops[i], hit);
                exp_clip |= hit;
            end
        end else begin
            for (int i = 0; i < n; i++) exp_val += ops[i];
            exp_val = exp_val & 1023;
            if (exp_val >= 512) exp_val -= 1024;
            exp_val = clamp_n(exp_val, hit);
            exp_clip = hit;
        end
        held = $signed(result_o);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 1) check({req, " R9"}, "clip clear after start", int'(clip_o), 0);
            start_i    = (i == 0);
            mode_i     = (i == 0) ? mode : ~mode;
            in_valid_i = 1'b1;
            in_data_i  = ops[i][N-1:0];
            in_last_i  = (i == n - 1);
        end
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
        check({req, " R8"}, "no early done", int'(done_o), 0);
        check({req, " R8"}, "result held before store", int'($signed(result_o)), held);
        @(negedge clk);
        check({req, " R8"}, "done pulse", int'(done_o), 1);
        check(req, "result", int'($signed(result_o)), exp_val);
        check({req, " R9"}, "clip", int'(clip_o), int'(exp_clip));
        @(negedge clk);
        check({req, " R8"}, "done single", int'(done_o), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "result", int'(result_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "clip", int'(clip_o), 0);
    endtask

    // R10: operands with no open run are ignored
    task automatic t_idle();
        int held = $signed(result_o);
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = 8'd33; in_last_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R10", "no done when idle", int'(done_o), 0);
            check("R10", "result unchanged", int'($signed(result_o)), held);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        run_case("R2",  1'b0, 3, '{10, 20, -5, 0, 0, 0, 0, 0});
        run_case("R2",  1'b0, 1, '{55, 0, 0, 0, 0, 0, 0, 0});
        run_case("R5",  1'b0, 2, '{96, 64, 0, 0, 0, 0, 0, 0});
        run_case("R5",  1'b1, 2, '{96, 64, 0, 0, 0, 0, 0, 0});
        run_case("R4",  1'b0, 3, '{100, 100, -90, 0, 0, 0, 0, 0});
        run_case("R7",  1'b1, 3, '{100, 100, -90, 0, 0, 0, 0, 0});
        run_case("R7",  1'b1, 3, '{96, 64, -32, 0, 0, 0, 0, 0});
        run_case("R4",  1'b0, 8, '{127, 127, 127, 127, 127, -127, -127, -127});
        run_case("R6",  1'b0, 2, '{-100, -100, 0, 0, 0, 0, 0, 0});
        run_case("R6",  1'b1, 2, '{-128, -1, 0, 0, 0, 0, 0, 0});
        run_case("R3",  1'b1, 3, '{127, -128, 127, 0, 0, 0, 0, 0});
        run_case("R11", 1'b0, 3, '{100, 100, -90, 0, 0, 0, 0, 0});
        run_case("R11", 1'b1, 3, '{100, 100, -90, 0, 0, 0, 0, 0});
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule